// File: doc/BRIEF.md
# RTC Interrupt Control and Compensation Tick

This block holds the control byte of a real-time clock and turns event flags from the rest of the clock into a single active-low interrupt request. It runs on the 32.768 kHz clock domain. Software writes and reads the byte through a plain write-strobe and read-data port. Three event sources reach the block: a time-update flag, a fixed-cycle timer flag and an alarm flag. A source raises the interrupt only while its enable bit is set. Update and timer requests drop by themselves after a fixed window. An alarm request stays until its enable is cleared. The output is a drive-low enable, which the pad ring turns into an open-drain pin.

The same byte carries a 2-bit interval select. A free-running counter uses it to emit a one-cycle pulse that starts the temperature compensation. The counter restarts whenever the select value changes, so the first pulse after a change always lands one full new interval later.

Top module: `rtc_intctl`

## Requirements
- R1: A write stores the byte. Bits 7:6 are the interval select, bit 5 is the update enable, bit 4 the timer enable, bit 3 the alarm enable and bit 0 a stored reset bit. Read-back shows the stored fields at those positions.
- R2: Bits 2 and 1 ignore writes and always read as 0, so writing 8'hFF reads back 8'hF9.
- R3: After reset the byte reads 8'h40 (select 01, all enables 0). The interrupt is released and no compensation pulse is present.
- R4: An update or timer event is sampled on the clock edge where its flag is first seen high after being low. It drives the interrupt low from that edge on, but only if its enable bit is 1. With the enable at 0 the output stays released.
- R5: An update or timer request releases itself exactly RELEASE_CYCLES (default 256, about 7.8 ms) clock edges after its event.
- R6: Writing 0 to an enable bit releases that source's request from the write edge on.
- R7: A new event on a source that is already active restarts that source's full release window.
- R8: The update and timer sources keep separate release windows. The output is low while either one, or the alarm, is active.
- R9: An alarm event with the alarm enable set holds the interrupt low, with no time limit, until the alarm enable is written 0.
- R10: A one-cycle compensation pulse repeats every N clock cycles. N is chosen by the select value: 00 gives TICKS_SEL0 (16384, 0.5 s), 01 gives TICKS_SEL1 (65536, 2 s), 10 gives TICKS_SEL2 (327680, 10 s) and 11 gives TICKS_SEL3 (983040, 30 s).
- R11: A write that changes the select value restarts the interval count, so the next pulse comes N(new) cycles after that write. A write that keeps the same select value does not disturb the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr_en | input | 1 | Write strobe for the control byte |
| ctrl_wr_data | input | 8 | Byte to store |
| ctrl_rd_data | output | 8 | Control byte read-back, with the protected bits forced to 0 |
| upd_flag | input | 1 | Time-update event flag |
| tmr_flag | input | 1 | Fixed-cycle timer event flag |
| alm_flag | input | 1 | Alarm event flag |
| int_drive_low | output | 1 | 1 pulls the interrupt pin low, 0 leaves it high-impedance |
| comp_tick | output | 1 | One-cycle compensation trigger pulse |

## Verification
The interrupt path is tried with several patterns:
- A single enabled event, which shows the exact release edge.
- An event with the enable at 0, which shows the gating.
- A second rising edge part-way through a window, which separates a restart from a plain hold.
- Overlapping update and timer events, which tell per-source windows apart from a shared one.
- An enable cleared mid-window, which shows the cancel.
- A long alarm hold, which shows that the alarm never self-releases.

The interval counter is measured between pulses, then after a same-value write and after a changed-value write, which separates a restart from an undisturbed count.

// File: rtl/rtc_intctl_pkg.sv
package rtc_intctl_pkg;

  // Stored fields of the control byte.
  typedef struct packed {
    logic [1:0] csel;
    logic       upd_en;
    logic       tmr_en;
    logic       alm_en;
    logic       rst_bit;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{csel: 2'b01, upd_en: 1'b0, tmr_en: 1'b0,
                                   alm_en: 1'b0, rst_bit: 1'b0};

  // The byte layout; bits 2:1 are protected and read as zero.
  function automatic logic [7:0] pack_ctrl(ctrl_t c);
    return {c.csel, c.upd_en, c.tmr_en, c.alm_en, 2'b00, c.rst_bit};
  endfunction

  function automatic ctrl_t unpack_ctrl(logic [7:0] b);
    ctrl_t c;
    c.csel    = b[7:6];
    c.upd_en  = b[5];
    c.tmr_en  = b[4];
    c.alm_en  = b[3];
    c.rst_bit = b[0];
    return c;
  endfunction

  // Interval length in clock cycles for a select code.
  function automatic logic [31:0] interval_span(logic [1:0] sel,
                                                int unsigned t0, int unsigned t1,
                                                int unsigned t2, int unsigned t3);
    case (sel)
      2'b00:   return 32'(t0);
      2'b01:   return 32'(t1);
      2'b10:   return 32'(t2);
      default: return 32'(t3);
    endcase
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Counter width able to hold n-1 (at least one bit).
  function automatic int unsigned count_width(int unsigned n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_intctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output ctrl_t      ctrl_o,
  output logic       sel_restart_o,
  output logic [7:0] rd_data_o
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_w;

  assign ctrl_w = unpack_ctrl(wr_data_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else if (wr_en_i) begin
      ctrl_q <= ctrl_w;
    end
  end

  // Only a change of the select value restarts the interval counter.
  assign sel_restart_o = wr_en_i && (ctrl_w.csel != ctrl_q.csel);
  assign ctrl_o        = ctrl_q;
  assign rd_data_o     = pack_ctrl(ctrl_q);

endmodule

// File: rtl/rtc_pulse_source.sv
module rtc_pulse_source
  import rtc_intctl_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  input  logic en_i,
  output logic event_o,
  output logic active_o,
  output logic drive_o
);

  localparam int unsigned CW = count_width(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic          flag_q;
  logic          active_q;
  logic [CW-1:0] hold_cnt_q;

  assign event_o = flag_i & ~flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q     <= 1'b0;
      active_q   <= 1'b0;
      hold_cnt_q <= '0;
    end else begin
      flag_q <= flag_i;
      if (event_o && en_i) begin
        active_q   <= 1'b1;
        hold_cnt_q <= '0;
      end else if (!en_i) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        if (hold_cnt_q == LAST) begin
          active_q <= 1'b0;
        end else begin
          hold_cnt_q <= hold_cnt_q + 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;
  // Gating with the live enable cancels at the write edge itself.
  assign drive_o  = active_q & en_i;

endmodule

// File: rtl/rtc_held_source.sv
module rtc_held_source (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  input  logic en_i,
  output logic event_o,
  output logic active_o,
  output logic drive_o
);

  logic flag_q;
  logic active_q;

  assign event_o = flag_i & ~flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      flag_q <= flag_i;
      if (event_o && en_i) begin
        active_q <= 1'b1;
      end else if (!en_i) begin
        active_q <= 1'b0;
      end
    end
  end

  assign active_o = active_q;
  assign drive_o  = active_q & en_i;

endmodule

// File: rtl/rtc_comp_ticker.sv
module rtc_comp_ticker
  import rtc_intctl_pkg::*;
#(
  parameter int unsigned TICKS_SEL0 = 16384,
  parameter int unsigned TICKS_SEL1 = 65536,
  parameter int unsigned TICKS_SEL2 = 327680,
  parameter int unsigned TICKS_SEL3 = 983040
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  input  logic       restart_i,
  output logic       tick_o,
  output logic       wrap_o
);

  localparam int unsigned TMAX = max4(TICKS_SEL0, TICKS_SEL1, TICKS_SEL2, TICKS_SEL3);
  localparam int unsigned CW   = count_width(TMAX);

  logic [31:0]   span;
  logic [CW-1:0] last;
  logic [CW-1:0] cnt_q;
  logic          tick_q;

  assign span   = interval_span(sel_i, TICKS_SEL0, TICKS_SEL1, TICKS_SEL2, TICKS_SEL3);
  assign last   = CW'(span - 32'd1);
  assign wrap_o = (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (wrap_o) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/rtc_intctl.sv
module rtc_intctl
  import rtc_intctl_pkg::*;
#(
  parameter int unsigned RELEASE_CYCLES = 256,
  parameter int unsigned TICKS_SEL0     = 16384,
  parameter int unsigned TICKS_SEL1     = 65536,
  parameter int unsigned TICKS_SEL2     = 327680,
  parameter int unsigned TICKS_SEL3     = 983040
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr_en,
  input  logic [7:0] ctrl_wr_data,
  output logic [7:0] ctrl_rd_data,
  input  logic       upd_flag,
  input  logic       tmr_flag,
  input  logic       alm_flag,
  output logic       int_drive_low,
  output logic       comp_tick
);

  localparam int unsigned NUM_TIMED = 2;

  ctrl_t ctrl;
  logic  sel_restart;
  logic  comp_wrap;

  logic [NUM_TIMED-1:0] timed_flag;
  logic [NUM_TIMED-1:0] timed_en;
  logic [NUM_TIMED-1:0] timed_event;
  logic [NUM_TIMED-1:0] timed_active;
  logic [NUM_TIMED-1:0] timed_drive;

  logic alm_event;
  logic alm_active;
  logic alm_drive;

  // Named internal events, brought out for the checker.
  logic upd_event;
  logic tmr_event;
  logic upd_active;
  logic tmr_active;

  rtc_ctrl_reg u_reg (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (ctrl_wr_en),
    .wr_data_i     (ctrl_wr_data),
    .ctrl_o        (ctrl),
    .sel_restart_o (sel_restart),
    .rd_data_o     (ctrl_rd_data)
  );

  assign timed_flag = {tmr_flag, upd_flag};
  assign timed_en   = {ctrl.tmr_en, ctrl.upd_en};

  for (genvar g = 0; g < NUM_TIMED; g++) begin : g_timed
    rtc_pulse_source #(
      .HOLD_CYCLES (RELEASE_CYCLES)
    ) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .flag_i   (timed_flag[g]),
      .en_i     (timed_en[g]),
      .event_o  (timed_event[g]),
      .active_o (timed_active[g]),
      .drive_o  (timed_drive[g])
    );
  end

  rtc_held_source u_alm (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_i   (alm_flag),
    .en_i     (ctrl.alm_en),
    .event_o  (alm_event),
    .active_o (alm_active),
    .drive_o  (alm_drive)
  );

  assign upd_event  = timed_event[0];
  assign tmr_event  = timed_event[1];
  assign upd_active = timed_active[0];
  assign tmr_active = timed_active[1];

  assign int_drive_low = (|timed_drive) | alm_drive;

  rtc_comp_ticker #(
    .TICKS_SEL0 (TICKS_SEL0),
    .TICKS_SEL1 (TICKS_SEL1),
    .TICKS_SEL2 (TICKS_SEL2),
    .TICKS_SEL3 (TICKS_SEL3)
  ) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (ctrl.csel),
    .restart_i (sel_restart),
    .tick_o    (comp_tick),
    .wrap_o    (comp_wrap)
  );

endmodule

// File: rtl/rtc_intctl_chk.sv
module rtc_intctl_chk #(
  parameter int unsigned RELEASE_CYCLES = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rd_data,
  input logic       int_low,
  input logic       tick,
  input logic       upd_event,
  input logic       tmr_event,
  input logic       upd_active,
  input logic       tmr_active,
  input logic       alm_active,
  input logic       sel_restart,
  input logic       comp_wrap
);

  int unsigned upd_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_run <= 0;
    else if (upd_event || !upd_active) upd_run <= 0;
    else upd_run <= upd_run + 1;
  end

  assert_protected_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[2:1] == 2'b00);

  assert_upd_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_active) |-> $past(upd_event && rd_data[5]));

  assert_tmr_needs_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_active) |-> $past(tmr_event && rd_data[4]));

  assert_release_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_active |-> (upd_run < RELEASE_CYCLES));

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5:3] == 3'b000) |-> !int_low);

  assert_drive_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_low |-> (upd_active || tmr_active || alm_active));

  assert_alarm_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_active && rd_data[3]) |=> alm_active);

  assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_tick_follows_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick) |-> $past(comp_wrap));

  assert_restart_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_restart |=> !tick);

endmodule

bind rtc_intctl rtc_intctl_chk #(
  .RELEASE_CYCLES (RELEASE_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_data     (ctrl_rd_data),
  .int_low     (int_drive_low),
  .tick        (comp_tick),
  .upd_event   (upd_event),
  .tmr_event   (tmr_event),
  .upd_active  (upd_active),
  .tmr_active  (tmr_active),
  .alm_active  (alm_active),
  .sel_restart (sel_restart),
  .comp_wrap   (comp_wrap)
);

// File: tb/sim_rtc_intctl.sv
module sim_rtc_intctl;

  localparam int CLK_PERIOD = 10;
  localparam int REL = 256;
  localparam int T0 = 300;
  localparam int T1 = 500;
  localparam int T2 = 700;
  localparam int T3 = 900;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_wr_en;
  logic [7:0] ctrl_wr_data;
  logic [7:0] ctrl_rd_data;
  logic       upd_flag, tmr_flag, alm_flag;
  logic       int_drive_low;
  logic       comp_tick;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_intctl #(
    .RELEASE_CYCLES (REL),
    .TICKS_SEL0 (T0), .TICKS_SEL1 (T1), .TICKS_SEL2 (T2), .TICKS_SEL3 (T3)
  ) u0 (
    .clk (clk), .rst_n (rst_n),
    .ctrl_wr_en (ctrl_wr_en), .ctrl_wr_data (ctrl_wr_data), .ctrl_rd_data (ctrl_rd_data),
    .upd_flag (upd_flag), .tmr_flag (tmr_flag), .alm_flag (alm_flag),
    .int_drive_low (int_drive_low), .comp_tick (comp_tick)
  );

  // ---------------- behavioural reference model ----------------
  int   m_sel, m_ctr, u_left, t_left;
  bit   m_ue, m_te, m_ae, m_rb, a_on, pu, pt, pa, m_tick;

  function automatic int span_of(int s);
    int spans[4] = '{T0, T1, T2, T3};
    return spans[s];
  endfunction

  function automatic logic [7:0] exp_byte();
    return 8'((m_sel << 6) | (m_ue << 5) | (m_te << 4) | (m_ae << 3) | m_rb);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_sel = 1; m_ue = 0; m_te = 0; m_ae = 0; m_rb = 0;
      u_left = 0; t_left = 0; a_on = 0; pu = 0; pt = 0; pa = 0;
      m_ctr = 0; m_tick = 0;
    end else begin
      if (!m_ue) u_left = 0;
      else if (upd_flag && !pu) u_left = REL;
      else if (u_left > 0) u_left--;
      if (!m_te) t_left = 0;
      else if (tmr_flag && !pt) t_left = REL;
      else if (t_left > 0) t_left--;
      if (!m_ae) a_on = 0;
      else if (alm_flag && !pa) a_on = 1;
      pu = upd_flag; pt = tmr_flag; pa = alm_flag;
      if (ctrl_wr_en && int'(ctrl_wr_data[7:6]) != m_sel) begin
        m_ctr = 0; m_tick = 0;
      end else if (m_ctr + 1 == span_of(m_sel)) begin
        m_ctr = 0; m_tick = 1;
      end else begin
        m_ctr++; m_tick = 0;
      end
      if (ctrl_wr_en) begin
        m_sel = int'(ctrl_wr_data[7:6]);
        m_ue = ctrl_wr_data[5]; m_te = ctrl_wr_data[4];
        m_ae = ctrl_wr_data[3]; m_rb = ctrl_wr_data[0];
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk("R1/R2 readback", 32'(ctrl_rd_data), 32'(exp_byte()));
      chk("R4/R5/R6/R8/R9 interrupt", 32'(int_drive_low),
          32'(((u_left > 0) && m_ue) || ((t_left > 0) && m_te) || (a_on && m_ae)));
      chk("R10/R11 tick", 32'(comp_tick), 32'(m_tick));
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v);
    ctrl_wr_en = 1'b1; ctrl_wr_data = v;
    @(negedge clk);
    ctrl_wr_en = 1'b0;
  endtask

  task automatic next_tick(output int at);
    @(negedge clk);
    while (comp_tick !== 1'b1) @(negedge clk);
    at = cyc;
  endtask

  initial begin
    int ta, tb, tw;
    rst_n = 1'b0; ctrl_wr_en = 1'b0; ctrl_wr_data = 8'h00;
    upd_flag = 0; tmr_flag = 0; alm_flag = 0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    chk("R3 reset byte", 32'(ctrl_rd_data), 32'h40);
    chk("R3 reset int", 32'(int_drive_low), 0);
    chk("R3 reset tick", 32'(comp_tick), 0);

    wr(8'hFF);
    chk("R1 all-ones write", 32'(ctrl_rd_data), 32'hF9);
    wr(8'h06);
    chk("R2 protected bits only", 32'(ctrl_rd_data), 32'h00);
    wr(8'h20);

    // R4 / R5 single event
    upd_flag = 1; wait_n(1);
    chk("R4 enabled event drives", 32'(int_drive_low), 1);
    wait_n(REL - 1);
    chk("R5 still held before window end", 32'(int_drive_low), 1);
    wait_n(1);
    chk("R5 released at window end", 32'(int_drive_low), 0);
    upd_flag = 0;

    // R4 disabled source
    wr(8'h00);
    tmr_flag = 1; wait_n(2);
    chk("R4 disabled event ignored", 32'(int_drive_low), 0);
    tmr_flag = 0;

    // R7 retrigger
    wr(8'h20);
    upd_flag = 1; wait_n(101);
    upd_flag = 0; wait_n(1);
    upd_flag = 1; wait_n(1);
    wait_n(REL - 1);
    chk("R7 retrigger extends window", 32'(int_drive_low), 1);
    wait_n(1);
    chk("R7 release after restarted window", 32'(int_drive_low), 0);
    upd_flag = 0; wait_n(1);

    // R6 cancel
    upd_flag = 1; wait_n(11);
    upd_flag = 0;
    chk("R6 active before cancel", 32'(int_drive_low), 1);
    wr(8'h00);
    chk("R6 cancel releases", 32'(int_drive_low), 0);

    // R8 overlapping sources
    wr(8'h30);
    upd_flag = 1; wait_n(50);
    tmr_flag = 1; wait_n(1);
    wait_n(210);
    chk("R8 timer holds after update ends", 32'(int_drive_low), 1);
    wait_n(50);
    chk("R8 both released", 32'(int_drive_low), 0);
    upd_flag = 0; tmr_flag = 0;

    // R9 alarm hold
    wr(8'h08);
    alm_flag = 1; wait_n(600);
    chk("R9 alarm still held", 32'(int_drive_low), 1);
    wr(8'h00);
    chk("R9 alarm cleared by enable", 32'(int_drive_low), 0);
    alm_flag = 0;

    // R10 / R11 interval ticks (select 00 is current)
    next_tick(ta);
    next_tick(tb);
    chk("R10 select 00 interval", 32'(tb - ta), 32'(T0));
    wait_n(100);
    wr(8'h00);
    next_tick(ta);
    chk("R11 same-select write keeps count", 32'(ta - tb), 32'(T0));
    wait_n(100);
    wr(8'hC0);
    tw = cyc;
    chk("R1 select field readback", 32'(ctrl_rd_data), 32'hC0);
    next_tick(tb);
    chk("R11 changed select restarts", 32'(tb - tw), 32'(T3));
    next_tick(ta);
    chk("R10 select 11 interval", 32'(ta - tb), 32'(T3));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule